// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block is the device side of a small serial EEPROM. A host selects it with a chip-select line and then clocks in one bit per clock: a start bit, a two-bit opcode, an address and, for commands that carry data, a data field. The block decodes the frame and performs the command on an internal 512-byte store. The commands are read, write, single-cell erase, whole-array erase, whole-array fill, write-enable and write-disable.

An organisation input selects the word size while a frame is being received. With it low, the store is seen as 512 bytes addressed by 9 bits. With it high, the store is seen as 256 16-bit words addressed by 8 bits. The four commands that carry no real address share opcode 00 and are told apart by the two leading address bits.

Write-type commands change the store only while an enable latch is set. After an accepted write-type command, the output line reports busy (0) for a fixed time and then ready (1). A parameter can leave the top address bit undecoded, which models a half-size array.

Top module: `mwire_eeprom`

## Requirements
- R1: While `cs` is high and the block is idle, 0 bits on `di` are skipped. The first 1 is taken as the start bit of a frame.
- R2: The two bits after the start bit are the opcode, first bit received as the high bit: 10 read, 01 write, 11 erase, 00 special. For 00, the first two address bits received select the command: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all. The remaining address bits are ignored.
- R3: With `org`=0 the address is 9 bits and the data is 8 bits. With `org`=1 the address is 8 bits and the data is 16 bits. Word w covers byte 2w (upper half) and byte 2w+1 (lower half). All fields are sent MSB first.
- R4: For a read, `dout` is 0 in the cycle after the last address bit is sampled. The data then follows MSB first, one bit per clock.
- R5: The enable latch is cleared by reset, set by write-enable and cleared by write-disable. While the latch is clear, write, erase, erase-all and write-all change no cell and produce no busy phase.
- R6: Erase sets the addressed byte or word to all ones. Erase-all sets every cell to all ones.
- R7: Write-all stores its data value (a byte or a word, according to `org`) in every location.
- R8: After the last bit of an accepted write, erase or write-all, `dout` is 0 for a set number of clocks and then 1 until `cs` falls. That number is `BUSY_CYC` for single-cell commands and the number of word rows for erase-all and write-all.
- R9: If `cs` falls before a frame is complete, the frame is discarded and no cell changes. The next frame is received normally.
- R10: With `HALF_ARRAY`=1, the top address bit is not decoded. Addresses in the upper half reach the same cells as the matching addresses in the lower half.
- R11: After reset, the block is idle and `dout` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| org | input | 1 | Word size: 0 for bytes, 1 for 16-bit words |
| di | input | 1 | Serial command, address and data input |
| dout | output | 1 | Registered serial output: read data or busy/ready |

## Verification
Two functions can meet on the same clock edge. When the last frame bit arrives, it is both decoded as a command and, for a read, used as the address that the memory port fetches. For a write, the same edge both decides acceptance against the enable latch and starts the busy phase. The bench makes every read depend on this shared edge. It sweeps all 512 byte addresses with arithmetic data, reads the store back as 16-bit words, and checks the dummy bit and the busy count on every command. It also drops chip select one bit before a frame would complete, then checks that the store is unchanged and that the next frame decodes normally.

// File: rtl/mwire_pkg.sv
package mwire_pkg;
  typedef enum logic [2:0] {
    K_READ, K_WRITE, K_ERASE, K_WEN, K_WDS, K_ERAL, K_WRAL
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_RD, S_BUSY, S_END
  } st_e;
endpackage

// File: rtl/mw_bank.sv
module mw_bank #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_decode.sv
module mw_decode
  import mwire_pkg::*;
#(
  parameter int AB   = 9,
  parameter bit HALF = 1'b0
) (
  input  logic [AB+1:0] frame,
  input  logic          org,
  output cmd_e          cmd,
  output logic [AB-2:0] row,
  output logic          bsel
);
  localparam int RW = AB - 1;

  logic [1:0] op;
  logic [1:0] top;

  always_comb begin
    if (org) begin
      op   = frame[AB:AB-1];
      top  = frame[AB-2:AB-3];
      row  = frame[AB-2:0];
      bsel = 1'b0;
    end else begin
      op   = frame[AB+1:AB];
      top  = frame[AB-1:AB-2];
      row  = frame[AB-1:1];
      bsel = frame[0];
    end
    if (HALF) row[RW-1] = 1'b0;
    case (op)
      2'b10:   cmd = K_READ;
      2'b01:   cmd = K_WRITE;
      2'b11:   cmd = K_ERASE;
      default: begin
        case (top)
          2'b11:   cmd = K_WEN;
          2'b00:   cmd = K_WDS;
          2'b10:   cmd = K_ERAL;
          default: cmd = K_WRAL;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
  import mwire_pkg::*;
#(
  parameter int ADDR_BITS  = 9,
  parameter bit HALF_ARRAY = 1'b0,
  parameter int BUSY_CYC   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic org,
  input  logic di,
  output logic dout
);
  localparam int HW   = ADDR_BITS + 2;
  localparam int RW   = ADDR_BITS - 1;
  localparam int ROWS = 1 << RW;
  localparam int CW   = $clog2(ROWS + BUSY_CYC + 32);

  st_e            st;
  logic [CW-1:0]  cnt;
  logic [HW-2:0]  hsh;
  logic [14:0]    dsh;
  logic [15:0]    osh;
  logic           wel_q, dout_q;
  cmd_e           cmd_q;
  logic [RW-1:0]  row_q;
  logic           bsel_q, rsel_q, rorg_q;

  logic           bulk_q, en0_q, en1_q;
  logic [7:0]     wr0_q, wr1_q;
  logic [RW-1:0]  wrow_q;

  logic [HW-1:0]  frame;
  logic [15:0]    dword;
  cmd_e           dec_cmd;
  logic [RW-1:0]  dec_row;
  logic           dec_bsel;
  logic [CW-1:0]  hlast, dlast, rlast, blast;
  logic [7:0]     rd0, rd1;
  logic [15:0]    rword;

  assign frame = {hsh, di};
  assign dword = {dsh, di};
  assign hlast = org ? CW'(HW - 2) : CW'(HW - 1);
  assign dlast = org ? CW'(15) : CW'(7);
  assign rlast = rorg_q ? CW'(15) : CW'(7);
  assign blast = bulk_q ? CW'(ROWS - 1) : CW'(BUSY_CYC - 1);
  assign rword = rorg_q ? {rd0, rd1} : {(rsel_q ? rd1 : rd0), 8'h00};
  assign dout  = dout_q;

  mw_decode #(.AB(ADDR_BITS), .HALF(HALF_ARRAY)) dec_i (
    .frame(frame), .org(org), .cmd(dec_cmd), .row(dec_row), .bsel(dec_bsel)
  );

  // Command acceptance: last header bit of erase/erase-all, or last data bit.
  logic          hdr_end, dat_end, acc, acc_bsel, acc_bulk, acc_wide;
  cmd_e          acc_cmd;
  logic [RW-1:0] acc_row;
  logic [15:0]   fill;

  always_comb begin
    hdr_end  = (st == S_HDR) && cs && (cnt == hlast);
    dat_end  = (st == S_DATA) && cs && (cnt == dlast);
    acc      = wel_q && (dat_end ||
               (hdr_end && (dec_cmd == K_ERASE || dec_cmd == K_ERAL)));
    acc_cmd  = (st == S_DATA) ? cmd_q : dec_cmd;
    acc_row  = (st == S_DATA) ? row_q : dec_row;
    acc_bsel = (st == S_DATA) ? bsel_q : dec_bsel;
    acc_bulk = (acc_cmd == K_ERAL) || (acc_cmd == K_WRAL);
    acc_wide = acc_bulk || org;
    if (acc_cmd == K_ERASE || acc_cmd == K_ERAL) fill = 16'hFFFF;
    else if (org)                                 fill = dword;
    else                                          fill = {dword[7:0], dword[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bulk_q <= 1'b0; en0_q <= 1'b0; en1_q <= 1'b0;
      wr0_q  <= '0;   wr1_q <= '0;   wrow_q <= '0;
    end else if (acc) begin
      bulk_q <= acc_bulk;
      en0_q  <= acc_wide || !acc_bsel;
      en1_q  <= acc_wide || acc_bsel;
      wr0_q  <= fill[15:8];
      wr1_q  <= fill[7:0];
      wrow_q <= acc_row;
    end
  end

  // Memory: even bytes / upper word halves in bank 0, odd bytes in bank 1.
  logic          we0, we1, wstep;
  logic [RW-1:0] waddr;

  assign wstep = (st == S_BUSY) && (bulk_q || cnt == '0);
  assign we0   = wstep && en0_q;
  assign we1   = wstep && en1_q;
  assign waddr = bulk_q ? cnt[RW-1:0] : wrow_q;

  mw_bank #(.AW(RW)) bank0_i (
    .clk(clk), .we(we0), .waddr(waddr), .wdata(wr0_q), .raddr(dec_row), .rdata(rd0)
  );
  mw_bank #(.AW(RW)) bank1_i (
    .clk(clk), .we(we1), .waddr(waddr), .wdata(wr1_q), .raddr(dec_row), .rdata(rd1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; hsh <= '0; dsh <= '0; osh <= '0;
      wel_q <= 1'b0; dout_q <= 1'b1; cmd_q <= K_READ; row_q <= '0;
      bsel_q <= 1'b0; rsel_q <= 1'b0; rorg_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          dout_q <= 1'b1;
          cnt    <= '0;
          hsh    <= '0;
          if (cs && di) st <= S_HDR;
        end
        S_HDR: begin
          if (!cs) st <= S_IDLE;
          else begin
            hsh <= frame[HW-2:0];
            cnt <= cnt + CW'(1);
            if (cnt == hlast) begin
              cnt <= '0; cmd_q <= dec_cmd; row_q <= dec_row; bsel_q <= dec_bsel;
              case (dec_cmd)
                K_READ: begin
                  st <= S_RD; dout_q <= 1'b0; rsel_q <= dec_bsel; rorg_q <= org;
                end
                K_WRITE, K_WRAL: begin st <= S_DATA; dsh <= '0; end
                K_WEN: begin wel_q <= 1'b1; st <= S_END; end
                K_WDS: begin wel_q <= 1'b0; st <= S_END; end
                default: begin st <= wel_q ? S_BUSY : S_END; dout_q <= !wel_q; end
              endcase
            end
          end
        end
        S_DATA: begin
          if (!cs) st <= S_IDLE;
          else begin
            dsh <= dword[14:0];
            cnt <= cnt + CW'(1);
            if (cnt == dlast) begin
              cnt <= '0; st <= wel_q ? S_BUSY : S_END; dout_q <= !wel_q;
            end
          end
        end
        S_RD: begin
          if (!cs) begin st <= S_IDLE; dout_q <= 1'b1; end
          else begin
            cnt <= cnt + CW'(1);
            if (cnt == '0) begin dout_q <= rword[15]; osh <= {rword[14:0], 1'b0}; end
            else begin dout_q <= osh[15]; osh <= {osh[14:0], 1'b0}; end
            if (cnt == rlast) begin cnt <= '0; st <= S_END; end
          end
        end
        S_BUSY: begin
          cnt <= cnt + CW'(1);
          if (cnt == blast) begin cnt <= '0; st <= S_END; dout_q <= 1'b1; end
        end
        S_END: begin
          dout_q <= 1'b1;
          if (!cs) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout_q && st == S_IDLE));
  // R1
  lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !(cs && di)) |=> st == S_IDLE);
  // R4
  dummy_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD && $past(st) == S_HDR) |-> !dout_q);
  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (we0 || we1) |-> wel_q);
  // R8
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY) |-> !dout_q);
  // R9
  cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs && (st == S_HDR || st == S_DATA || st == S_RD)) |=> st == S_IDLE);
endmodule

// File: tb/mwire_eeprom_tb_top.sv
module mwire_eeprom_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 5;
  localparam int ROWS       = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs  = 1'b0;
  logic org = 1'b0;
  logic di  = 1'b0;
  logic dout, dout_h;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [512];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mwire_eeprom #(.ADDR_BITS(9), .HALF_ARRAY(1'b0), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst(rst), .cs(cs), .org(org), .di(di), .dout(dout)
  );
  mwire_eeprom #(.ADDR_BITS(9), .HALF_ARRAY(1'b1), .BUSY_CYC(BUSY)) dut_h (
    .clk(clk), .rst(rst), .cs(cs), .org(org), .di(di), .dout(dout_h)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic frame_out(input bit o, input logic [1:0] op, input logic [8:0] a,
                           input int lead);
    logic [10:0] hdr;
    int n;
    n   = o ? 10 : 11;
    hdr = o ? {1'b0, op, a[7:0]} : {op, a};
    @(negedge clk);
    org = o; cs = 1'b1;
    for (int i = 0; i < lead; i++) begin di = 1'b0; @(negedge clk); end
    di = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin @(negedge clk); di = hdr[i]; end
  endtask

  task automatic end_cmd();
    cs = 1'b0; di = 1'b0;
  endtask

  task automatic rd(input bit o, input logic [8:0] a, input int lead, input string r,
                    input logic [15:0] exp, output logic [15:0] vh);
    logic [15:0] v;
    int dw;
    dw = o ? 16 : 8;
    frame_out(o, 2'b10, a, lead);
    @(negedge clk);
    chk(dout == 1'b0, "R4 dummy bit", 32'(dout), 0);
    v = '0; vh = '0;
    for (int i = 0; i < dw; i++) begin
      @(negedge clk);
      v  = {v[14:0], dout};
      vh = {vh[14:0], dout_h};
    end
    end_cmd();
    chk(v == exp, r, 32'(v), 32'(exp));
  endtask

  task automatic wr(input bit o, input logic [1:0] op, input logic [8:0] a,
                    input logic [15:0] d, input bit hasd, input int busy, input string r);
    bit ok;
    frame_out(o, op, a, 0);
    if (hasd) begin
      for (int i = (o ? 15 : 7); i >= 0; i--) begin @(negedge clk); di = d[i]; end
    end
    if (busy == 0) begin
      @(negedge clk);
      chk(dout == 1'b1, r, 32'(dout), 1);
    end else begin
      ok = 1'b1;
      for (int k = 0; k < busy; k++) begin
        @(negedge clk);
        if (dout !== 1'b0) ok = 1'b0;
      end
      @(negedge clk);
      if (dout !== 1'b1) ok = 1'b0;
      chk(ok, r, 32'(ok), 1);
    end
    end_cmd();
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] vh;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(dout == 1'b1 && dout_h == 1'b1, "R11 idle dout", 32'({dout, dout_h}), 32'h3);

    // R5: enable latch clear after reset, writes ignored
    wr(0, 2'b01, 9'd3, 16'h0012, 1, 0, "R5 write ignored after reset");
    // R2 R5 write-enable with don't-care bits, then erase-all (R6 R8)
    wr(0, 2'b00, 9'b11_0101101, 16'h0, 0, 0, "R2 WEN no busy");
    wr(0, 2'b00, 9'b10_1100110, 16'h0, 0, ROWS, "R8 erase-all busy length");
    for (int a = 0; a < 512; a++) mdl[a] = 8'hFF;
    rd(0, 9'd3, 0, "R6 erase-all byte", 16'h00FF, vh);
    rd(1, 9'd200, 0, "R6 erase-all word", 16'hFFFF, vh);

    // R2 R5 write-disable then ignored write
    wr(0, 2'b00, 9'b00_1111111, 16'h0, 0, 0, "R2 WDS no busy");
    wr(0, 2'b01, 9'd3, 16'h0012, 1, 0, "R5 write ignored after WDS");
    rd(0, 9'd3, 0, "R5 cell unchanged", 16'h00FF, vh);

    // R3 R8 byte sweep with busy check, word readback
    wr(1, 2'b00, 9'b0_11000000, 16'h0, 0, 0, "R2 WEN x16");
    for (int a = 0; a < 512; a++) begin
      wr(0, 2'b01, 9'(a), 16'(pat(a)), 1, BUSY, "R8 byte write busy");
      mdl[a] = pat(a);
    end
    for (int w = 0; w < 256; w++)
      rd(1, 9'(w), 0, "R3 word readback", {mdl[2*w], mdl[2*w+1]}, vh);

    // R5 bulk commands ignored while disabled
    wr(0, 2'b00, 9'b00_0000000, 16'h0, 0, 0, "R2 WDS");
    wr(0, 2'b00, 9'b10_0000000, 16'h0, 0, 0, "R5 erase-all ignored");
    wr(1, 2'b00, 9'b0_01000000, 16'h1234, 1, 0, "R5 write-all ignored");
    wr(0, 2'b11, 9'd14, 16'h0, 0, 0, "R5 erase ignored");
    rd(1, 9'd7, 0, "R5 word intact", {mdl[14], mdl[15]}, vh);
    wr(0, 2'b00, 9'b11_0000000, 16'h0, 0, 0, "R2 WEN");

    // R3 word write, byte readback
    wr(1, 2'b01, 9'h40, 16'hBEEF, 1, BUSY, "R8 word write busy");
    mdl[9'h80] = 8'hBE; mdl[9'h81] = 8'hEF;
    rd(0, 9'h80, 0, "R3 upper byte of word", 16'h00BE, vh);
    rd(0, 9'h81, 0, "R3 lower byte of word", 16'h00EF, vh);

    // R6 single erase, both sizes
    wr(0, 2'b11, 9'h81, 16'h0, 0, BUSY, "R8 erase busy");
    mdl[9'h81] = 8'hFF;
    rd(1, 9'h40, 0, "R6 byte erase", 16'hBEFF, vh);
    wr(1, 2'b11, 9'h41, 16'h0, 0, BUSY, "R8 word erase busy");
    mdl[9'h82] = 8'hFF; mdl[9'h83] = 8'hFF;
    rd(0, 9'h82, 0, "R6 word erase upper", 16'h00FF, vh);
    rd(0, 9'h83, 0, "R6 word erase lower", 16'h00FF, vh);
    rd(0, 9'h84, 0, "R6 neighbour intact", 16'(mdl[9'h84]), vh);

    // R1 leading zeros
    rd(0, 9'h80, 5, "R1 leading zeros", 16'h00BE, vh);
    rd(1, 9'h10, 2, "R1 leading zeros x16", {mdl[32], mdl[33]}, vh);

    // R9 abort mid-data, then a normal frame
    frame_out(0, 2'b01, 9'd10, 0);
    for (int i = 0; i < 7; i++) begin @(negedge clk); di = 1'b0; end
    @(negedge clk);
    end_cmd();
    rd(0, 9'd10, 0, "R9 aborted write", 16'(mdl[10]), vh);
    frame_out(0, 2'b10, 9'd12, 0);
    @(negedge clk);
    end_cmd();
    wr(0, 2'b01, 9'd11, 16'h00A5, 1, BUSY, "R9 frame after abort");
    mdl[11] = 8'hA5;
    rd(0, 9'd11, 0, "R9 post-abort write", 16'h00A5, vh);

    // R7 write-all in both sizes
    wr(1, 2'b00, 9'b0_01101011, 16'h5A3C, 1, ROWS, "R8 write-all busy");
    rd(1, 9'd0, 0, "R7 write-all word 0", 16'h5A3C, vh);
    rd(1, 9'd127, 0, "R7 write-all word 127", 16'h5A3C, vh);
    rd(1, 9'd255, 0, "R7 write-all word 255", 16'h5A3C, vh);
    wr(0, 2'b00, 9'b01_1010101, 16'h0077, 1, ROWS, "R8 write-all x8 busy");
    rd(1, 9'd64, 0, "R7 write-all byte", 16'h7777, vh);
    rd(0, 9'd511, 0, "R7 write-all last byte", 16'h0077, vh);

    // R10 half array: upper addresses alias onto lower half
    wr(0, 2'b00, 9'b10_0000000, 16'h0, 0, ROWS, "R8 erase-all");
    wr(0, 2'b01, 9'h1A5, 16'h009C, 1, BUSY, "R8 write upper");
    rd(0, 9'h0A5, 0, "R10 full array no alias", 16'h00FF, vh);
    chk(vh == 16'h009C, "R10 half array alias", 32'(vh), 32'h9C);
    rd(0, 9'h1A5, 0, "R10 full array upper", 16'h009C, vh);
    chk(vh == 16'h009C, "R10 half array upper", 32'(vh), 32'h9C);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule